// File: doc/BRIEF.md
# Dual-Port GPIO Controller with Parallel-Interface Override

This block controls two 16-pin general-purpose I/O ports from a small core-side register bus. Each port holds an output-value register and a direction register. A read-only image shows the level currently seen on each pad. Bit X of every per-port register belongs to pin X. Toward the pad model, each pin gets an output value and an output enable. The block takes each pad level back in through a two-flop synchronizer.

A parallel interface next to the block can take pins over. The bench describes ownership to the block with per-pin masks: which pins are claimed, the value to drive, a control-select mask, a direction mask and a transfer-active mask. A parameter marks which pins are control lines. A claimed control pin is driven while its control-select bit is set. A claimed data pin is driven only while its direction bit says output and a transfer is active. Whenever the interface drives a pin, its value and enable take priority over the normal register programming. A claimed pin that the interface is not driving stays an input, so the interface can listen on it.

Register map: address bits [1:0] select the register and the bits above them select the port. Offset 0 is output data, offset 1 is direction and offset 2 is the input image. Offset 3 reads as zero. Reads are combinational from the current address.

Top module: `gpio_altport`

## Requirements
- R1: After reset, the output-data and direction registers of both ports read 0, and every pad_oe bit is 0.
- R2: A write with bus_we high at offset 0 stores bus_wdata in the output-data register, and a write at offset 1 stores it in the direction register. The write lands on the rising edge. Address bit 2 selects the port (0 = pins 0..15, 1 = pins 16..31). A later read of the same address returns the stored value.
- R3: The input image (offset 2) shows the pad_i level of the addressed port two rising edges after pad_i changes. After only one edge it still shows the previous level.
- R4: On an unclaimed pin whose direction bit is 0, pad_oe is 0. Writes to output data are still stored. When the direction bit is later set to 1, the stored value appears on pad_o with pad_oe 1.
- R5: On an unclaimed pin whose direction bit is 1, pad_oe is 1 and pad_o equals its output-data bit. The input image still returns the pad_i level, not the driven value.
- R6: Writes at offset 2 or 3 change neither the output-data nor the direction register of either port.
- R7: A claimed control pin (CTL_PINS bit set, default pins 12..15 of each port) whose alt_cs bit is 1 has pad_oe 1 and pad_o equal to alt_val, whatever its direction bit is.
- R8: A claimed data pin (CTL_PINS bit clear) has pad_oe 1 and pad_o equal to alt_val only while both alt_dir and alt_xfer are 1 for that pin.
- R9: A claimed pin that the alternate function is not driving has pad_oe 0 even when its direction bit is 1. Alternate inputs have no effect on unclaimed pins.
- R10: Writes to one port leave the other port's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address: [1:0] register, [2] port |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| pad_i | input | 32 | Pad levels, port 1 in bits 31..16 |
| pad_o | output | 32 | Output value toward the pads |
| pad_oe | output | 32 | Output enable toward the pads |
| alt_claim | input | 32 | Pin owned by the parallel interface |
| alt_val | input | 32 | Alternate output value |
| alt_cs | input | 32 | Control-select mask for control pins |
| alt_dir | input | 32 | Parallel direction mask (1 = output) for data pins |
| alt_xfer | input | 32 | Transfer-active mask for data pins |

## Verification
The bench builds the block with its default parameters: two ports of 16 pins, a two-stage synchronizer and control pins 12..15. With two ports, the port-select address bit and cross-port isolation can be tested. The control mask places both control and data pins in each port, so both alternate rules run side by side. With two stages, the lag before the input image changes is exactly two edges, and the bench samples on both sides of it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int REG_SEL_W = 2;

   typedef enum logic [REG_SEL_W-1:0] {
      REG_DOUT = 2'd0,
      REG_DIR  = 2'd1,
      REG_DIN  = 2'd2,
      REG_NONE = 2'd3
   } gpio_reg_e;

   function automatic int sel_width(input int nports);
      return (nports > 1) ? $clog2(nports) : 1;
   endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
         $error("gpio_in_sync: STAGES must be 2..4");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign dout = stg[STAGES-1];

   logic [2:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 warm <= '0;
      else if (warm < 3'(STAGES)) warm <= warm + 3'd1;
   end

   AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 3'(STAGES)) |-> (dout == $past(din, STAGES))); // R3
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_pkg::*;
#(
   parameter int W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_SEL_W-1:0] wr_sel,
   input  logic [W-1:0]         wr_data,
   output logic [W-1:0]         dout_q,
   output logic [W-1:0]         dir_q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("gpio_port_regs: W must be at least 1");
      end
   endgenerate

   logic hit_dout, hit_dir;
   always_comb begin
      hit_dout = wr_en && (gpio_reg_e'(wr_sel) == REG_DOUT);
      hit_dir  = wr_en && (gpio_reg_e'(wr_sel) == REG_DIR);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         dir_q  <= '0;
      end else begin
         if (hit_dout) dout_q <= wr_data;
         if (hit_dir)  dir_q  <= wr_data;
      end
   end

   AST_DOUT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0) |=> (dout_q == $past(wr_data))); // R2
   AST_DIR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1) |=> (dir_q == $past(wr_data))); // R2
   AST_RO_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel[1]) |=> ($stable(dout_q) && $stable(dir_q))); // R6
   AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> ($stable(dout_q) && $stable(dir_q))); // R10
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
   parameter int           W        = 16,
   parameter logic [W-1:0] CTL_PINS = '0
) (
   input  logic [W-1:0] dout_q,
   input  logic [W-1:0] dir_q,
   input  logic [W-1:0] alt_claim,
   input  logic [W-1:0] alt_val,
   input  logic [W-1:0] alt_cs,
   input  logic [W-1:0] alt_dir,
   input  logic [W-1:0] alt_xfer,
   output logic [W-1:0] pad_o,
   output logic [W-1:0] pad_oe
);
   logic [W-1:0] alt_en;

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_pin
         if (CTL_PINS[i]) begin : g_ctl
            assign alt_en[i] = alt_claim[i] & alt_cs[i];
         end else begin : g_data
            assign alt_en[i] = alt_claim[i] & alt_dir[i] & alt_xfer[i];
         end
         assign pad_oe[i] = alt_en[i] | (~alt_claim[i] & dir_q[i]);
         assign pad_o[i]  = alt_en[i] ? alt_val[i] : dout_q[i];
      end
   endgenerate
endmodule

// File: rtl/gpio_altport.sv
module gpio_altport
   import gpio_pkg::*;
#(
   parameter int               NUM_PORTS   = 2,
   parameter int               PIN_W       = 16,
   parameter int               SYNC_STAGES = 2,
   parameter logic [PIN_W-1:0] CTL_PINS    = 16'hF000,
   localparam int              PSEL_W      = sel_width(NUM_PORTS),
   localparam int              ADDR_W      = REG_SEL_W + PSEL_W,
   localparam int              ALL_W       = NUM_PORTS * PIN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [PIN_W-1:0]  bus_wdata,
   output logic [PIN_W-1:0]  bus_rdata,
   input  logic [ALL_W-1:0]  pad_i,
   output logic [ALL_W-1:0]  pad_o,
   output logic [ALL_W-1:0]  pad_oe,
   input  logic [ALL_W-1:0]  alt_claim,
   input  logic [ALL_W-1:0]  alt_val,
   input  logic [ALL_W-1:0]  alt_cs,
   input  logic [ALL_W-1:0]  alt_dir,
   input  logic [ALL_W-1:0]  alt_xfer
);
   generate
      if (NUM_PORTS < 1) begin : g_bad_ports
         $error("gpio_altport: NUM_PORTS must be at least 1");
      end
      if (PIN_W < 1 || PIN_W > 64) begin : g_bad_pins
         $error("gpio_altport: PIN_W must be 1..64");
      end
   endgenerate

   localparam logic [ALL_W-1:0] CTL_ALL = {NUM_PORTS{CTL_PINS}};

   logic [PSEL_W-1:0]    port_sel;
   logic [REG_SEL_W-1:0] reg_sel;
   assign port_sel = bus_addr[ADDR_W-1:REG_SEL_W];
   assign reg_sel  = bus_addr[REG_SEL_W-1:0];

   logic [PIN_W-1:0] dout_a [NUM_PORTS];
   logic [PIN_W-1:0] dir_a  [NUM_PORTS];
   logic [PIN_W-1:0] din_a  [NUM_PORTS];
   logic [ALL_W-1:0] dout_flat, dir_flat;

   genvar p;
   generate
      for (p = 0; p < NUM_PORTS; p++) begin : g_port
         logic wr_here;
         assign wr_here = bus_we && (port_sel == PSEL_W'(p));

         gpio_port_regs #(.W(PIN_W)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_here),
            .wr_sel  (reg_sel),
            .wr_data (bus_wdata),
            .dout_q  (dout_a[p]),
            .dir_q   (dir_a[p])
         );

         gpio_in_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (pad_i[p*PIN_W +: PIN_W]),
            .dout  (din_a[p])
         );

         gpio_pin_mux #(.W(PIN_W), .CTL_PINS(CTL_PINS)) u_mux (
            .dout_q    (dout_a[p]),
            .dir_q     (dir_a[p]),
            .alt_claim (alt_claim[p*PIN_W +: PIN_W]),
            .alt_val   (alt_val[p*PIN_W +: PIN_W]),
            .alt_cs    (alt_cs[p*PIN_W +: PIN_W]),
            .alt_dir   (alt_dir[p*PIN_W +: PIN_W]),
            .alt_xfer  (alt_xfer[p*PIN_W +: PIN_W]),
            .pad_o     (pad_o[p*PIN_W +: PIN_W]),
            .pad_oe    (pad_oe[p*PIN_W +: PIN_W])
         );

         assign dout_flat[p*PIN_W +: PIN_W] = dout_a[p];
         assign dir_flat[p*PIN_W +: PIN_W]  = dir_a[p];
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int q = 0; q < NUM_PORTS; q++) begin
         if (port_sel == PSEL_W'(q)) begin
            case (gpio_reg_e'(reg_sel))
               REG_DOUT: bus_rdata = dout_a[q];
               REG_DIR:  bus_rdata = dir_a[q];
               REG_DIN:  bus_rdata = din_a[q];
               default:  bus_rdata = '0;
            endcase
         end
      end
   end

   logic [ALL_W-1:0] ctl_own, data_own;
   assign ctl_own  = alt_claim & CTL_ALL & alt_cs;
   assign data_own = alt_claim & ~CTL_ALL;

   AST_CTL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctl_own & ~pad_oe) == '0) && ((ctl_own & (pad_o ^ alt_val)) == '0)); // R7
   AST_DATA_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      ((data_own & alt_dir & alt_xfer & ~pad_oe) == '0)); // R8
   AST_CLAIM_IDLE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      ((data_own & ~(alt_dir & alt_xfer) & pad_oe) == '0) &&
      ((alt_claim & CTL_ALL & ~alt_cs & pad_oe) == '0)); // R9
   AST_UNCLAIMED_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      ((~alt_claim & (pad_oe ^ dir_flat)) == '0)); // R4
   AST_UNCLAIMED_VAL: assert property (@(posedge clk) disable iff (!rst_n)
      ((~alt_claim & pad_oe & (pad_o ^ dout_flat)) == '0)); // R5
endmodule

// File: tb/gpio_altport_bench.sv
module gpio_altport_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [31:0] pad_i = '0;
   logic [31:0] pad_o, pad_oe;
   logic [31:0] alt_claim = '0, alt_val = '0, alt_cs = '0, alt_dir = '0, alt_xfer = '0;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   gpio_altport u_gpio_altport (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_i(pad_i),
      .pad_o(pad_o), .pad_oe(pad_oe), .alt_claim(alt_claim), .alt_val(alt_val),
      .alt_cs(alt_cs), .alt_dir(alt_dir), .alt_xfer(alt_xfer)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [15:0] d;
      rd(3'd0, d); check("R1 dout p0", {16'h0, d}, 32'h0);
      rd(3'd1, d); check("R1 dir p0", {16'h0, d}, 32'h0);
      rd(3'd4, d); check("R1 dout p1", {16'h0, d}, 32'h0);
      rd(3'd5, d); check("R1 dir p1", {16'h0, d}, 32'h0);
      check("R1 pad_oe", pad_oe, 32'h0);
   endtask

   task automatic t_regs_rw();
      logic [15:0] d;
      wr(3'd0, 16'hA5C3);
      wr(3'd5, 16'h0F0F);
      rd(3'd0, d); check("R2 dout p0", {16'h0, d}, 32'hA5C3);
      rd(3'd5, d); check("R2 dir p1", {16'h0, d}, 32'h0F0F);
      rd(3'd4, d); check("R10 dout p1 untouched", {16'h0, d}, 32'h0);
      rd(3'd1, d); check("R10 dir p0 untouched", {16'h0, d}, 32'h0);
      rd(3'd3, d); check("R2 offset3 reads 0", {16'h0, d}, 32'h0);
      wr(3'd0, 16'h0000);
      wr(3'd5, 16'h0000);
   endtask

   task automatic t_sync();
      logic [15:0] d;
      @(negedge clk);
      pad_i = 32'h1234_BEEF;
      @(negedge clk);
      rd(3'd2, d); check("R3 p0 after one edge", {16'h0, d}, 32'h0);
      @(negedge clk);
      rd(3'd2, d); check("R3 p0 after two edges", {16'h0, d}, 32'hBEEF);
      rd(3'd6, d); check("R3 p1 after two edges", {16'h0, d}, 32'h1234);
   endtask

   task automatic t_input_mode();
      wr(3'd0, 16'h00FF);
      #1 check("R4 oe off while dir 0", pad_oe, 32'h0);
      wr(3'd1, 16'h0003);
      #1 check("R4 oe after dir set", pad_oe, 32'h0000_0003);
      check("R4 stored value driven", pad_o & 32'h3, 32'h3);
   endtask

   task automatic t_output_mode();
      logic [15:0] d;
      wr(3'd1, 16'hFFFF);
      wr(3'd0, 16'h5A5A);
      @(negedge clk);
      pad_i[15:0] = 16'h0F0F;
      repeat (2) @(negedge clk);
      check("R5 pad_oe p0", pad_oe, 32'h0000_FFFF);
      check("R5 pad_o p0", {16'h0, pad_o[15:0]}, 32'h5A5A);
      rd(3'd2, d); check("R5 din reads pad", {16'h0, d}, 32'h0F0F);
   endtask

   task automatic t_ro_write();
      logic [15:0] d;
      wr(3'd2, 16'h1111);
      wr(3'd3, 16'h2222);
      wr(3'd6, 16'h3333);
      rd(3'd0, d); check("R6 dout p0 kept", {16'h0, d}, 32'h5A5A);
      rd(3'd1, d); check("R6 dir p0 kept", {16'h0, d}, 32'hFFFF);
      rd(3'd4, d); check("R6 dout p1 kept", {16'h0, d}, 32'h0);
      rd(3'd5, d); check("R6 dir p1 kept", {16'h0, d}, 32'h0);
   endtask

   task automatic t_ctl_alt();
      @(negedge clk);
      wr(3'd1, 16'h0000);
      alt_claim = 32'h3000_3000;
      alt_val   = 32'h1000_2000;
      alt_cs    = 32'h3000_3000;
      #1;
      check("R7 ctl oe", pad_oe & 32'h3000_3000, 32'h3000_3000);
      check("R7 ctl val", pad_o & 32'h3000_3000, 32'h1000_2000);
      alt_cs = 32'h0;
      #1 check("R9 ctl released", pad_oe, 32'h0);
      alt_claim = '0; alt_val = '0;
   endtask

   task automatic t_data_alt();
      wr(3'd1, 16'h00F0);
      alt_claim = 32'h0000_00F0;
      alt_val   = 32'h0000_00A0;
      alt_dir   = 32'h0000_00F0;
      alt_xfer  = 32'h0000_0000;
      #1 check("R9 claimed idle no oe", pad_oe, 32'h0);
      alt_xfer = 32'h0000_00F0;
      #1 check("R8 data oe", pad_oe, 32'h0000_00F0);
      check("R8 data val", pad_o & 32'hF0, 32'h0000_00A0);
      alt_dir = 32'h0000_0030;
      #1 check("R8 dir gates", pad_oe, 32'h0000_0030);
      alt_claim = 32'h0; alt_cs = 32'hFFFF_FFFF;
      #1 check("R9 unclaimed ignores alt", pad_oe, 32'h0000_00F0);
      check("R9 unclaimed value", pad_o & 32'hF0, 32'h0000_0050);
      alt_cs = '0; alt_dir = '0; alt_xfer = '0; alt_val = '0;
   endtask

   initial begin
      #1_000_000;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs_rw();
      t_sync();
      t_input_mode();
      t_output_mode();
      t_ro_write();
      t_ctl_alt();
      t_data_alt();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule